// File: doc/BRIEF.md
# Page Write Collector and Committer

This block gathers the data bytes of one page-programming operation and then commits the whole page to a byte-wide memory array during a timed internal write cycle. A command front end, which has already decoded the serial stream and checked write protection, opens a session with a start strobe that carries the first address. It then presents each data byte with a byte strobe. When the chip select is released on a valid byte boundary, the front end raises a commit strobe.

Only whole-page programming is supported. The page is selected by the upper address bits, which stay fixed for the whole session. Incoming bytes land at an in-page slot that advances by one and wraps at the page end, so a long burst overwrites bytes that were collected earlier. Any slot that received no byte is written as 0xFF, which gives a defined result after a short burst.

Once committed, the block holds a busy flag for a fixed number of clocks. In the first page-size clocks of that window it writes the page to the array one byte per clock, in ascending offset order. When the window ends, a one-clock done pulse tells the front end to clear its write-enable latch.

Top module: `pageWriteBuffer`

## Requirements
- R1: After reset, busy, cycleDone and arrWe are all 0.
- R2: A start strobe while not busy opens a fresh session. The page is startAddr[ADDR_W-1:7], the first slot is startAddr[6:0], and all bytes collected earlier are discarded.
- R3: In an open session, each byte strobe stores byteData at the current slot, and the slot then advances by one modulo 128. The page number does not change.
- R4: When more than 128 bytes arrive, the slot wraps to 0, and for each offset the last byte received is the one that is written.
- R5: Every page offset that received no byte in the session is written to the array as 0xFF.
- R6: A commit strobe in an open session raises busy from the next clock. Busy then stays high for exactly CYCLE_CLKS clocks.
- R7: During the first 128 clocks of busy, arrWe is 1 and arrAddr is {page, k} on the k-th busy clock (k = 0..127). During the remaining busy clocks, arrWe is 0.
- R8: cycleDone is a single-clock pulse in the first clock after busy falls, and the session is then closed.
- R9: Start, byte and commit strobes that arrive while busy are ignored. They do not change the written data, the addresses or the length of the busy window.
- R10: With no session open, a byte strobe or a commit strobe has no effect, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Opens a page session |
| startAddr | input | ADDR_W | First byte address of the session |
| byteStb | input | 1 | A data byte is valid |
| byteData | input | DATA_W | Data byte |
| commitStb | input | 1 | Select released on a byte boundary; starts the internal cycle |
| busy | output | 1 | Internal write cycle in progress |
| cycleDone | output | 1 | One-clock pulse at the end of the cycle (clears write enable) |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | ADDR_W | Array write address |
| arrData | output | DATA_W | Array write data |

## Verification
The page path is tried with four kinds of session:
- A full 128-byte burst from offset 0 shows that each byte goes to the right slot.
- A 200-byte burst from offset 100 separates wrap-and-overwrite from saturation or spill into the next page.
- Short and empty bursts show that unreceived slots are filled with 0xFF and not with stale data.
- Seeded random sessions, with random start offsets and lengths, cover mixes that the directed cases miss.

Strobes injected in the middle of a busy window, and strobes sent with no session open, show whether the control honours its ignore rules.

// File: rtl/pwbPkg.sv
package pwbPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BUSY = 2'd2
  } pwbState_t;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic beginPage;   // capture page and first slot, drop old bytes
    logic storeByte;   // store byteData at current slot, advance slot
    logic beginDrain;  // rewind the drain pointer
    logic emitByte;    // present one array write this clock
  } pwbStrobes_t;

endpackage

// File: rtl/pwbCtrl.sv
module pwbCtrl
  import pwbPkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int CYCLE_CLKS = 160
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        byteStb,
  input  logic        commitStb,
  output pwbStrobes_t stb,
  output logic        busy,
  output logic        cycleDone
);

  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

  pwbState_t        state;
  logic [CNT_W-1:0] cycCnt;

  always_comb begin
    stb            = '0;
    stb.beginPage  = (state != ST_BUSY) && startStb;
    stb.beginDrain = (state == ST_FILL) && commitStb && !startStb;
    stb.storeByte  = (state == ST_FILL) && byteStb && !startStb && !commitStb;
    stb.emitByte   = (state == ST_BUSY) && (cycCnt < PAGE_CNT);
  end

  assign busy = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cycCnt    <= '0;
      cycleDone <= 1'b0;
    end else begin
      cycleDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startStb) state <= ST_FILL;
        end
        ST_FILL: begin
          if (stb.beginDrain) begin
            state  <= ST_BUSY;
            cycCnt <= '0;
          end
        end
        ST_BUSY: begin
          if (cycCnt == LAST_CNT) begin
            state     <= ST_IDLE;
            cycleDone <= 1'b1;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwbData.sv
module pwbData
  import pwbPkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobes_t       stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0]     pageBase;
  logic [IDX_W-1:0]      fillIdx;
  logic [IDX_W-1:0]      drainIdx;
  logic [PAGE_BYTES-1:0] slotValid;
  logic [DATA_W-1:0]     pageMem [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase  <= '0;
      fillIdx   <= '0;
      drainIdx  <= '0;
      slotValid <= '0;
    end else begin
      if (stb.beginPage) begin
        pageBase  <= startAddr[ADDR_W-1:IDX_W];
        fillIdx   <= startAddr[IDX_W-1:0];
        slotValid <= '0;
      end else if (stb.storeByte) begin
        slotValid[fillIdx] <= 1'b1;
        fillIdx            <= fillIdx + 1'b1;
      end
      if (stb.beginDrain) drainIdx <= '0;
      else if (stb.emitByte) drainIdx <= drainIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) pageMem[fillIdx] <= byteData;
  end

  assign arrWe   = stb.emitByte;
  assign arrAddr = {pageBase, drainIdx};
  assign arrData = slotValid[drainIdx] ? pageMem[drainIdx] : {DATA_W{1'b1}};

endmodule

// File: rtl/pageWriteBuffer.sv
module pageWriteBuffer
  import pwbPkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int CYCLE_CLKS = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              commitStb,
  output logic              busy,
  output logic              cycleDone,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  generate
    if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || CYCLE_CLKS < PAGE_BYTES ||
        ADDR_W <= $clog2(PAGE_BYTES)) begin : g_badParams
      $error("pageWriteBuffer: illegal parameter set");
    end
  endgenerate

  pwbStrobes_t stb;

  pwbCtrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .byteStb   (byteStb),
    .commitStb (commitStb),
    .stb       (stb),
    .busy      (busy),
    .cycleDone (cycleDone)
  );

  pwbData #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startAddr (startAddr),
    .byteData  (byteData),
    .arrWe     (arrWe),
    .arrAddr   (arrAddr),
    .arrData   (arrData)
  );

endmodule

// File: rtl/pwbChecker.sv
module pwbChecker #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int CYCLE_CLKS = 160
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStb,
  input logic              byteStb,
  input logic              commitStb,
  input logic              busy,
  input logic              cycleDone,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr,
  input logic [DATA_W-1:0] arrData
);

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = $clog2(CYCLE_CLKS + 2);

  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else       busyLen <= busy ? busyLen + 1'b1 : '0;
  end

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!busy && !arrWe) else $error("R1 outputs active in reset");
    end
  end

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commitStb));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (busyLen == LEN_W'(CYCLE_CLKS)));

  // R7
  we_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (arrWe == (busyLen < LEN_W'(PAGE_BYTES))));

  // R7
  we_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> (arrAddr[IDX_W-1:0] == busyLen[IDX_W-1:0]));

  // R7
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && $past(arrWe)) |-> (arrAddr[ADDR_W-1:IDX_W] == $past(arrAddr[ADDR_W-1:IDX_W])));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (!busy && $past(busy)));

  // R8
  done_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> cycleDone);

  // R7
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

endmodule

bind pageWriteBuffer pwbChecker #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PAGE_BYTES(PAGE_BYTES),
  .CYCLE_CLKS(CYCLE_CLKS)
) u_pwbChecker (
  .clk       (clk),
  .rstN      (rstN),
  .startStb  (startStb),
  .byteStb   (byteStb),
  .commitStb (commitStb),
  .busy      (busy),
  .cycleDone (cycleDone),
  .arrWe     (arrWe),
  .arrAddr   (arrAddr),
  .arrData   (arrData)
);

// File: tb/pageWriteBuffer_bench.sv
module pageWriteBuffer_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int PAGE   = 128;
  localparam int CYC    = 160;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startStb = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic              byteStb = 1'b0;
  logic [DATA_W-1:0] byteData = '0;
  logic              commitStb = 1'b0;
  logic              busy, cycleDone, arrWe;
  logic [ADDR_W-1:0] arrAddr;
  logic [DATA_W-1:0] arrData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] expMem [PAGE];
  bit                expGot [PAGE];
  logic [ADDR_W-8:0] expPage;
  int                expIdx;
  string             dataTag = "R3";

  always #2.5 clk = ~clk;

  pageWriteBuffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .CYCLE_CLKS(CYC)
  ) u_pageWriteBuffer (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .byteStb(byteStb), .byteData(byteData), .commitStb(commitStb),
    .busy(busy), .cycleDone(cycleDone), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrData(arrData)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] expByte(input int k);
    return expGot[k] ? expMem[k] : 8'hFF;
  endfunction

  task automatic openPage(input logic [ADDR_W-1:0] a);
    startStb = 1'b1; startAddr = a;
    @(negedge clk);
    startStb = 1'b0;
    expPage = a[ADDR_W-1:7];
    expIdx  = int'(a[6:0]);
    for (int i = 0; i < PAGE; i++) expGot[i] = 1'b0;
  endtask

  task automatic pushByte(input logic [DATA_W-1:0] d);
    byteStb = 1'b1; byteData = d;
    @(negedge clk);
    byteStb = 1'b0;
    expMem[expIdx] = d;
    expGot[expIdx] = 1'b1;
    expIdx = (expIdx + 1) % PAGE;
  endtask

  // Commit and follow the whole busy window; optionally inject strobes (R9)
  task automatic commitAndCheck(input bit inject);
    commitStb = 1'b1;
    @(negedge clk);
    commitStb = 1'b0;
    for (int k = 0; k < CYC; k++) begin
      check(busy == 1'b1, "R6", busy, 1);
      if (k < PAGE) begin
        check(arrWe == 1'b1, "R7", arrWe, 1);
        check(arrAddr == {expPage, 7'(k)}, "R7", arrAddr, {expPage, 7'(k)});
        check(arrData == expByte(k), expGot[k] ? dataTag : "R5", arrData, expByte(k));
      end else begin
        check(arrWe == 1'b0, "R7", arrWe, 0);
      end
      check(cycleDone == 1'b0, "R8", cycleDone, 0);
      startStb = 1'b0; byteStb = 1'b0; commitStb = 1'b0;
      if (inject) begin
        if (k == 2)   begin byteStb = 1'b1; byteData = 8'h5A; end
        if (k == 3)   begin startStb = 1'b1; startAddr = 17'h1_FF80; end
        if (k == 4)   commitStb = 1'b1;
        if (k == 140) commitStb = 1'b1;
      end
      @(negedge clk);
    end
    startStb = 1'b0; byteStb = 1'b0; commitStb = 1'b0;
    check(busy == 1'b0, "R6", busy, 0);
    check(cycleDone == 1'b1, "R8", cycleDone, 1);
    @(negedge clk);
    check(cycleDone == 1'b0, "R8", cycleDone, 0);
    check(busy == 1'b0, "R8", busy, 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1
    check(busy == 0 && cycleDone == 0 && arrWe == 0, "R1", {busy, cycleDone, arrWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && arrWe == 0, "R1", {busy, arrWe}, 0);

    // R10: no session open, byte and commit ignored
    pushByte(8'h11);
    commitStb = 1'b1; @(negedge clk); commitStb = 1'b0;
    repeat (2) begin
      check(busy == 1'b0 && arrWe == 1'b0, "R10", busy, 0);
      @(negedge clk);
    end

    // R3: full page from offset 0
    dataTag = "R3";
    openPage(17'h0_2300);
    for (int i = 0; i < PAGE; i++) pushByte(8'(i * 7 + 3));
    commitAndCheck(1'b0);

    // R10: session closed after the cycle
    commitStb = 1'b1; @(negedge clk); commitStb = 1'b0;
    check(busy == 1'b0, "R10", busy, 0);

    // R4: 200 bytes from offset 100, wrap and overwrite
    dataTag = "R4";
    openPage(17'h1_0464);
    for (int i = 0; i < 200; i++) pushByte(8'(i + 1));
    commitAndCheck(1'b0);

    // R2: restart discards earlier session
    dataTag = "R2";
    openPage(17'h0_0000);
    for (int i = 0; i < 20; i++) pushByte(8'hC3);
    openPage(17'h0_7F85);
    for (int i = 0; i < 6; i++) pushByte(8'(8'h40 + i));
    commitAndCheck(1'b0);

    // R5 and R9: short burst, strobes injected during busy
    dataTag = "R9";
    openPage(17'h0_520A);
    for (int i = 0; i < 5; i++) pushByte(8'(8'hA0 + i));
    commitAndCheck(1'b1);
    check(busy == 1'b0, "R9", busy, 0);

    // R5: empty session writes all 0xFF
    openPage(17'h1_2345);
    commitAndCheck(1'b0);

    // Random sessions
    dataTag = "R3";
    for (int s = 0; s < 10; s++) begin
      int n;
      openPage(ADDR_W'($urandom));
      n = int'($urandom_range(0, 300));
      for (int i = 0; i < n; i++) pushByte(8'($urandom));
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
      commitAndCheck(s[0]);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule